// File: doc/BRIEF.md
# Multi-cycle instruction step sequencer

This block is the control heart of a small multi-cycle processor core. It walks one instruction at a time through a fixed chain of micro-steps: instruction fetch, pointer update, decode, operand memory read, pointer advance past a trailing displacement or immediate, operand address arithmetic, operand delivery, execution and result write. Each step is held for as many clocks as the instruction's addressing mode, operand source and address alignment require. A step that needs no clocks at all is left out of the walk entirely.

Two instruction classes are handled. The first is an ALU operation whose destination is a register. The second is a store of a register into memory. The class, addressing mode, operand kind and address parity are presented with a one-clock start strobe and captured at that moment. The block reports the current step code and a busy flag. It pulses done after the final step and leaves the total number of clocks used on a counter output. Memory traffic, byte decoding and the arithmetic datapath sit outside the block.

Top module: `instr_step_seq`

## Requirements
- R1: While reset_n is low at a clock edge, and after that edge, step_code is 0 (idle), step_busy is 0, done is 0 and cycles_used is 0.
- R2: An ALU instruction (instr_store = 0) visits these step codes in order: 1 fetch, 2 pointer update, 3 decode, 4 operand read, 5 pointer advance, 6 address compute, 7 second-operand delivery, 8 first-operand read, 9 execute, 10 register write. Codes 1, 2, 3, 8, 9 and 10 each last one clock, and step 1 begins on the clock edge that samples an accepted start.
- R3: Step 4 lasts 0 clocks for addr_mode 0 (no memory operand) and addr_mode 1 (base register indirect). It lasts 1 clock for addr_mode 2 (direct displacement) or addr_mode 3 (displacement plus base) when addr_odd is 0, and 2 clocks when addr_odd is 1.
- R4: Step 5 lasts 1 clock when addr_mode is 2 or 3, or when an ALU instruction has opnd_kind 0 (constant). Otherwise it lasts 0 clocks.
- R5: Step 6 lasts 1 clock for addr_mode 1, 2 clocks for addr_mode 3 and 0 clocks for addr_mode 0 or 2.
- R6: Step 7 lasts 0 clocks for opnd_kind 0 (constant) and 1 clock for opnd_kind 1 (register). For opnd_kind 2 or 3 (memory) it lasts 2 clocks when addr_odd is 0 and 3 clocks when addr_odd is 1.
- R7: A store instruction (instr_store = 1) follows steps 1 to 6 under the same rules. It then takes step 11 (source register read, 1 clock) and step 12 (memory write, 1 clock when addr_odd is 0, 3 clocks when it is 1). It never enters steps 7 to 10.
- R8: A step whose length is zero is never shown on step_code. The next non-empty step follows with no idle clock, and step_busy stays 1 from the first step through the last.
- R9: In the clock after the final step, step_code is 0, step_busy is 0 and done is 1. Done is 1 for exactly that one clock.
- R10: cycles_used goes to 0 on the edge that accepts start. It then rises by one for each clock spent in a step and saturates at its maximum value. After done it holds the instruction's total until the next accepted start.
- R11: A start strobe sampled while step_busy is 1 has no effect, including in the last clock of the final step. The attribute inputs are used only as captured with an accepted start. Changing them later alters neither the step sequence nor the total.
- R12: A start sampled in the same clock as the done pulse is accepted. The next instruction's fetch step follows at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| instr_store | input | 1 | 0: ALU to register, 1: store register to memory |
| addr_mode | input | 2 | 0 none, 1 base indirect, 2 displacement, 3 displacement plus base |
| opnd_kind | input | 2 | 0 constant, 1 register, 2 or 3 memory |
| addr_odd | input | 1 | Memory address is odd |
| step_code | output | 4 | Current micro-step, 0 when idle |
| step_busy | output | 1 | High while a micro-step is in progress |
| done | output | 1 | One-clock pulse after the final step |
| cycles_used | output | CYC_W (5) | Clocks spent on the latest instruction |

## Verification
Two of the block's functions can meet in one clock: the done pulse, and the acceptance of a new start strobe. Directly before that clock sits the last clock of the final step, where a start must still be refused. The bench raises start in the final step clock and expects the block to fall idle and stay idle. It then raises start exactly on the done clock and expects the next fetch step at once, with the counter cleared and no idle gap. Strobes with changed attributes injected mid-instruction are judged by comparing the whole observed step trace and total against the trace built from the captured attributes.

// File: rtl/seq_pkg.sv
// Shared types and step-length rules for the instruction step sequencer.
// Assumes step codes are consumed externally as plain 4-bit numbers.
package seq_pkg;

    localparam int N_STEPS = 13;
    localparam int STEP_W  = 4;
    localparam int DUR_W   = 2;

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE    = 4'd0,
        ST_FETCH   = 4'd1,
        ST_IPUPD   = 4'd2,
        ST_DECODE  = 4'd3,
        ST_OPFETCH = 4'd4,
        ST_IPADV   = 4'd5,
        ST_ADDR    = 4'd6,
        ST_SRC     = 4'd7,
        ST_DST     = 4'd8,
        ST_EXEC    = 4'd9,
        ST_WBREG   = 4'd10,
        ST_RDREG   = 4'd11,
        ST_MEMWR   = 4'd12
    } step_e;

    typedef enum logic [1:0] {
        AM_NONE     = 2'd0,
        AM_BASE     = 2'd1,
        AM_DISP     = 2'd2,
        AM_DISPBASE = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        OK_CONST = 2'd0,
        OK_REG   = 2'd1,
        OK_MEM   = 2'd2,
        OK_MEM2  = 2'd3
    } okind_e;

    typedef struct packed {
        logic   is_store;
        amode_e mode;
        okind_e kind;
        logic   odd;
    } attr_t;

    // Number of clocks a step occupies for the given instruction attributes.
    function automatic logic [DUR_W-1:0] step_dur(step_e s, attr_t a);
        logic has_disp;
        has_disp = (a.mode == AM_DISP) || (a.mode == AM_DISPBASE);
        case (s)
            ST_FETCH, ST_IPUPD, ST_DECODE,
            ST_DST, ST_EXEC, ST_WBREG, ST_RDREG: step_dur = 2'd1;
            ST_OPFETCH: step_dur = has_disp ? (a.odd ? 2'd2 : 2'd1) : 2'd0;
            ST_IPADV:   step_dur = (has_disp || (!a.is_store && a.kind == OK_CONST)) ? 2'd1 : 2'd0;
            ST_ADDR:    step_dur = (a.mode == AM_BASE) ? 2'd1 :
                                   (a.mode == AM_DISPBASE) ? 2'd2 : 2'd0;
            ST_SRC:     step_dur = (a.kind == OK_CONST) ? 2'd0 :
                                   (a.kind == OK_REG) ? 2'd1 :
                                   (a.odd ? 2'd3 : 2'd2);
            ST_MEMWR:   step_dur = a.odd ? 2'd3 : 2'd1;
            default:    step_dur = 2'd0;
        endcase
    endfunction

    // Raw successor of a step in the class's fixed order, ignoring lengths.
    function automatic step_e succ_step(step_e s, logic is_store);
        case (s)
            ST_IDLE:    succ_step = ST_FETCH;
            ST_FETCH:   succ_step = ST_IPUPD;
            ST_IPUPD:   succ_step = ST_DECODE;
            ST_DECODE:  succ_step = ST_OPFETCH;
            ST_OPFETCH: succ_step = ST_IPADV;
            ST_IPADV:   succ_step = ST_ADDR;
            ST_ADDR:    succ_step = is_store ? ST_RDREG : ST_SRC;
            ST_SRC:     succ_step = ST_DST;
            ST_DST:     succ_step = ST_EXEC;
            ST_EXEC:    succ_step = ST_WBREG;
            ST_RDREG:   succ_step = ST_MEMWR;
            default:    succ_step = ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/seq_step_dur.sv
// Step length lookup: returns how many clocks a step takes for the given
// attributes. Purely combinational; idle and unknown codes give zero.
module seq_step_dur
    import seq_pkg::*;
(
    input  step_e             step,
    input  attr_t             attrs,
    output logic [DUR_W-1:0]  dur
);

    // Evaluate the shared length rule for one step.
    always_comb begin
        dur = step_dur(step, attrs);
    end

endmodule

// File: rtl/seq_next_step.sv
// Next-step selector: from the current step, walks the class's order and
// skips every step whose length is zero, so the sequencer never idles on an
// empty step. Returns idle after the last step. Assumes the order has at most
// N_STEPS entries, which bounds the look-ahead.
module seq_next_step
    import seq_pkg::*;
(
    input  step_e cur,
    input  attr_t attrs,
    output step_e nxt
);

    // Find the first non-empty step after the current one.
    always_comb begin
        step_e cand;
        cand = succ_step(cur, attrs.is_store);
        for (int i = 0; i < N_STEPS; i++) begin
            if (cand != ST_IDLE && step_dur(cand, attrs) == '0) begin
                cand = succ_step(cand, attrs.is_store);
            end
        end
        nxt = cand;
    end

endmodule

// File: rtl/seq_cycle_cnt.sv
// Saturating clock counter for the instruction total. Clears on clr, counts
// on en, and sticks at its all-ones value. Synchronous active-low reset.
module seq_cycle_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         reset_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    // Clear, count or hold the running total.
    always_ff @(posedge clk) begin
        if (!reset_n)                 count <= '0;
        else if (clr)                 count <= '0;
        else if (en && count != MAXV) count <= count + ONE;
    end

    // R10: the total never wraps past its maximum
    a_r10_saturate: assert property (@(posedge clk) disable iff (!reset_n)
        (count == MAXV && !clr) |=> (count == MAXV));

    // R10: an accepted start clears the total
    a_r10_clear: assert property (@(posedge clk) disable iff (!reset_n)
        clr |=> (count == '0));

endmodule

// File: rtl/instr_step_seq.sv
// Instruction step sequencer top. Captures the instruction attributes on an
// accepted start, then holds each micro-step for its attribute-dependent
// length, skipping empty steps, and pulses done after the final one.
// Assumes start is a single-clock strobe; strobes while busy are dropped.
module instr_step_seq
    import seq_pkg::*;
#(
    parameter int CYC_W = 5
) (
    input  logic             clk,
    input  logic             reset_n,
    input  logic             start,
    input  logic             instr_store,
    input  logic [1:0]       addr_mode,
    input  logic [1:0]       opnd_kind,
    input  logic             addr_odd,
    output logic [3:0]       step_code,
    output logic             step_busy,
    output logic             done,
    output logic [CYC_W-1:0] cycles_used
);

    localparam logic [DUR_W-1:0] DUR_ONE = {{(DUR_W-1){1'b0}}, 1'b1};

    attr_t             attr_in;
    attr_t             attr_q;
    attr_t             attr_sel;
    step_e             state;
    step_e             nxt;
    logic [DUR_W-1:0]  remain;
    logic [DUR_W-1:0]  nxt_dur;
    logic [DUR_W-1:0]  cur_dur;
    logic              done_q;
    logic              idle;
    logic              accept;

    // Pack the attribute inputs and pick the set that steers the look-ahead.
    always_comb begin
        attr_in.is_store = instr_store;
        attr_in.mode     = amode_e'(addr_mode);
        attr_in.kind     = okind_e'(opnd_kind);
        attr_in.odd      = addr_odd;
        idle             = (state == ST_IDLE);
        accept           = idle && start;
        attr_sel         = idle ? attr_in : attr_q;
    end

    seq_next_step u_next (
        .cur   (state),
        .attrs (attr_sel),
        .nxt   (nxt)
    );

    seq_step_dur u_dur_nxt (
        .step  (nxt),
        .attrs (attr_sel),
        .dur   (nxt_dur)
    );

    seq_step_dur u_dur_cur (
        .step  (state),
        .attrs (attr_q),
        .dur   (cur_dur)
    );

    // Step state machine: accept, hold, advance and signal completion.
    always_ff @(posedge clk) begin
        if (!reset_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            attr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (idle) begin
                if (start) begin
                    attr_q <= attr_in;
                    state  <= nxt;
                    remain <= nxt_dur - DUR_ONE;
                end
            end else if (remain == '0) begin
                state <= nxt;
                if (nxt == ST_IDLE) begin
                    remain <= '0;
                    done_q <= 1'b1;
                end else begin
                    remain <= nxt_dur - DUR_ONE;
                end
            end else begin
                remain <= remain - DUR_ONE;
            end
        end
    end

    seq_cycle_cnt #(.W(CYC_W)) u_cnt (
        .clk     (clk),
        .reset_n (reset_n),
        .clr     (accept),
        .en      (!idle),
        .count   (cycles_used)
    );

    // Drive the status outputs.
    always_comb begin
        step_code = state;
        step_busy = !idle;
        done      = done_q;
    end

    // R2: an accepted start always opens with the fetch step
    a_r2_fetch_first: assert property (@(posedge clk) disable iff (!reset_n)
        accept |=> (state == ST_FETCH));

    // R8: no step with zero length is ever occupied
    a_r8_step_nonzero: assert property (@(posedge clk) disable iff (!reset_n)
        !idle |-> (cur_dur != '0));

    // R8: the remaining count stays inside the occupied step's length
    a_r8_remain_bound: assert property (@(posedge clk) disable iff (!reset_n)
        !idle |-> (remain < cur_dur));

    // R9: done lasts one clock and coincides with idle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!reset_n)
        done_q |=> !done_q);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!reset_n)
        done_q |-> idle);

    // R11: captured attributes cannot change mid-instruction
    a_r11_attr_hold: assert property (@(posedge clk) disable iff (!reset_n)
        !idle |=> $stable(attr_q));

    // R3: the operand read step only occurs with a displacement mode
    a_r3_opfetch_mode: assert property (@(posedge clk) disable iff (!reset_n)
        (state == ST_OPFETCH) |-> (attr_q.mode == AM_DISP || attr_q.mode == AM_DISPBASE));

    // R7: a store never reaches the execute step
    a_r7_store_no_exec: assert property (@(posedge clk) disable iff (!reset_n)
        (!idle && attr_q.is_store) |-> (state != ST_EXEC));

endmodule

// File: tb/instr_step_seq_tb.sv
`timescale 1ns/1ps
module instr_step_seq_tb;

    logic       clk = 1'b0;
    logic       reset_n;
    logic       start;
    logic       instr_store;
    logic [1:0] addr_mode;
    logic [1:0] opnd_kind;
    logic       addr_odd;
    logic [3:0] step_code;
    logic       step_busy;
    logic       done;
    logic [4:0] cycles_used;

    int n_checks = 0;
    int n_err    = 0;
    int exp_tr [0:31];
    int exp_len;

    always #2.5 clk = ~clk;

    instr_step_seq u_dut (
        .clk         (clk),
        .reset_n     (reset_n),
        .start       (start),
        .instr_store (instr_store),
        .addr_mode   (addr_mode),
        .opnd_kind   (opnd_kind),
        .addr_odd    (addr_odd),
        .step_code   (step_code),
        .step_busy   (step_busy),
        .done        (done),
        .cycles_used (cycles_used)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic add(input int code, input int n);
        for (int i = 0; i < n; i++) begin
            exp_tr[exp_len] = code;
            exp_len++;
        end
    endtask

    // Expected step trace built from the requirement rules
    task automatic build(input bit cls, input int md, input int kd, input bit od);
        bit disp;
        disp = (md == 2) || (md == 3);
        exp_len = 0;
        add(1, 1); add(2, 1); add(3, 1);
        add(4, disp ? (od ? 2 : 1) : 0);
        add(5, (disp || (!cls && kd == 0)) ? 1 : 0);
        add(6, (md == 1) ? 1 : (md == 3) ? 2 : 0);
        if (!cls) begin
            add(7, (kd == 0) ? 0 : (kd == 1) ? 1 : (od ? 3 : 2));
            add(8, 1); add(9, 1); add(10, 1);
        end else begin
            add(11, 1);
            add(12, od ? 3 : 1);
        end
    endtask

    task automatic set_in(input bit cls, input int md, input int kd, input bit od);
        instr_store = cls;
        addr_mode   = md[1:0];
        opnd_kind   = kd[1:0];
        addr_odd    = od;
        start       = 1'b1;
    endtask

    task automatic launch(input bit cls, input int md, input int kd, input bit od);
        @(negedge clk);
        set_in(cls, md, kd, od);
        build(cls, md, kd, od);
    endtask

    // Follow a launched instruction; optionally raise a stray start with
    // scrambled attributes at trace index inj. Returns at the done clock.
    task automatic follow(input string req, input int inj);
        int mis;
        int first_act;
        int first_exp;
        mis = 0; first_act = 0; first_exp = 0;
        for (int k = 0; k < exp_len; k++) begin
            @(negedge clk);
            if (step_code != exp_tr[k][3:0] || !step_busy || done) begin
                if (mis == 0) begin
                    first_act = step_code;
                    first_exp = exp_tr[k];
                end
                mis++;
            end
            if (k == 0) chk(cycles_used == 5'd0, "R10", "count cleared on start", cycles_used, 0);
            if (k == inj) begin
                instr_store = ~instr_store;
                addr_mode   = ~addr_mode;
                opnd_kind   = ~opnd_kind;
                addr_odd    = ~addr_odd;
                start       = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        chk(mis == 0, req, "step trace first wrong code", first_act, first_exp);
        @(negedge clk);
        start = 1'b0;
        chk(step_code == 4'd0 && !step_busy, "R9", "idle after last step", step_code, 0);
        chk(done == 1'b1, "R9", "done pulse", done, 1);
        chk(cycles_used == exp_len[4:0], req, "total clocks", cycles_used, exp_len);
    endtask

    task automatic settle(input string req);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one clock only", done, 0);
        chk(step_code == 4'd0, req, "stays idle", step_code, 0);
        chk(cycles_used == exp_len[4:0], "R10", "total held", cycles_used, exp_len);
    endtask

    task automatic t_reset;
        reset_n = 1'b0;
        start   = 1'b1;
        set_in(1'b0, 3, 2, 1'b1);
        repeat (3) @(negedge clk);
        chk(step_code == 4'd0, "R1", "reset step", step_code, 0);
        chk(!step_busy && !done, "R1", "reset busy/done", {step_busy, done}, 0);
        chk(cycles_used == 5'd0, "R1", "reset count", cycles_used, 0);
        start   = 1'b0;
        reset_n = 1'b1;
        @(negedge clk);
        chk(step_code == 4'd0 && !step_busy, "R1", "idle after reset", step_code, 0);
    endtask

    task automatic t_alu_reg;
        launch(1'b0, 0, 1, 1'b0);
        follow("R2", -1);
        settle("R2");
        chk(exp_len == 7, "R2", "register ALU length", exp_len, 7);
    endtask

    task automatic t_alu_const;
        launch(1'b0, 0, 0, 1'b0);
        follow("R4", -1);
        settle("R8");
    endtask

    task automatic t_alu_base_mem;
        launch(1'b0, 1, 2, 1'b0);
        follow("R5", -1);
        settle("R5");
        launch(1'b0, 1, 3, 1'b1);
        follow("R6", -1);
        settle("R6");
    endtask

    task automatic t_alu_disp;
        launch(1'b0, 2, 2, 1'b1);
        follow("R3", -1);
        settle("R3");
        launch(1'b0, 2, 1, 1'b0);
        follow("R3", -1);
        settle("R4");
        launch(1'b0, 3, 2, 1'b1);
        follow("R6", -1);
        settle("R5");
    endtask

    task automatic t_store;
        launch(1'b1, 2, 0, 1'b0);
        follow("R7", -1);
        settle("R7");
        launch(1'b1, 3, 1, 1'b1);
        follow("R7", -1);
        settle("R7");
        launch(1'b1, 1, 2, 1'b0);
        follow("R7", -1);
        settle("R7");
        launch(1'b1, 0, 0, 1'b1);
        follow("R8", -1);
        settle("R8");
    endtask

    task automatic t_ignore;
        launch(1'b0, 2, 2, 1'b0);
        follow("R11", 3);
        settle("R11");
        launch(1'b1, 1, 1, 1'b0);
        follow("R11", exp_len - 1);
        settle("R11");
    endtask

    task automatic t_back2back;
        launch(1'b0, 0, 1, 1'b0);
        follow("R12", -1);
        set_in(1'b1, 3, 2, 1'b1);
        build(1'b1, 3, 2, 1'b1);
        follow("R12", -1);
        settle("R12");
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        reset_n = 1'b0;
        start   = 1'b0;
        t_reset();
        t_alu_reg();
        t_alu_const();
        t_alu_base_mem();
        t_alu_disp();
        t_store();
        t_ignore();
        t_back2back();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule